// File: doc/BRIEF.md
# 64-bit Timestamp Compare Timer

This block is a system timer reached over a simple 32-bit register bus with read and write strobes and a word index. It keeps a free-running timestamp that advances once every `TICK_DIV` input clocks (one microsecond when `TICK_DIV` matches the clock rate in MHz). It also holds a compare value which, when armed, raises a level interrupt as the timestamp reaches it.

The timestamp is wider than a bus word, so software reads it in two parts. Reading the lower part freezes the upper part in a shadow register, and the following upper read returns that frozen value, so the pair is always consistent. The compare value is written upper part first. The upper part is only staged; the lower write then loads the whole value in one step.

Arming uses a guarded control word. The enable bit only changes when its write-enable companion bit is set in the same write. A sticky hit flag records matches and is cleared by writing one to it. Software arms the timer by reading the count, writing a compare value at least 100 ticks ahead and setting the enable. It idles the timer by disabling, writing a zero compare value and clearing the flag.

Top module: `tstamp_cmp_timer`

## Requirements
- R1: After reset the timestamp is zero, and it then increases by exactly one on every `TICK_DIV`-th clock edge. It holds its value on all other edges.
- R2: A read of word index 0 returns the lower `SPLIT_W` bits of the timestamp, zero-extended, and captures the upper `CNT_W-SPLIT_W` bits into a shadow. A read of word index 1 returns that shadow, even if the live upper bits have changed since.
- R3: A write to word index 3 only stages the upper compare bits; the active compare value does not change. A write to word index 2 loads the active value as {staged upper, written lower}. Reads of indexes 2 and 3 return the active value's lower and upper bits.
- R4: In the control word (index 4), bit 1 is a write-enable for bit 0, the compare enable. A write updates the enable from bit 0 only when bit 1 is 1; otherwise the enable is unchanged. A read returns the enable in bit 0 and zero elsewhere.
- R5: When the compare is enabled and a tick advances the timestamp to the active compare value, the hit flag becomes 1 on that same clock edge. With the compare disabled, reaching the value sets nothing.
- R6: The hit flag (bit 0 of index 5) is sticky. Writing 1 to bit 0 clears it, and writing 0 leaves it unchanged. Disabling the compare does not clear it. If a match and a clearing write fall on the same edge, the flag stays set.
- R7: The interrupt output equals the hit flag ANDed with the compare enable.
- R8: Reads of word indexes 6 and 7 return zero, and writes to indexes 0 and 1 change nothing.
- R9: After reset the compare value, staged upper bits, shadow, enable, hit flag and read data are all zero. Read data is updated on the clock edge that samples the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | 3 | Word index of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| irq | output | 1 | Level interrupt: hit flag AND enable |

## Verification
A wrong prescaler or timestamp shows up at the first timestamp read after the fault. The value will be off by whole ticks, and that shows within `TICK_DIV` cycles of a divergence. A stale or missing shadow capture only shows when the lower part wraps between the two reads, so the bench places a read pair across a wrap. A bad compare path, enable guard or sticky flag shows on `irq` in the very cycle it goes wrong, because the interrupt is compared against a reference model on every clock. A register that keeps too much or too little state shows at the next read of that word.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

   typedef enum logic [2:0] {
      IDX_CNT_LO = 3'd0,
      IDX_CNT_HI = 3'd1,
      IDX_CMP_LO = 3'd2,
      IDX_CMP_HI = 3'd3,
      IDX_CTRL   = 3'd4,
      IDX_STAT   = 3'd5
   } tsc_idx_e;

   localparam int CTRL_EN_BIT  = 0;
   localparam int CTRL_WE_BIT  = 1;
   localparam int STAT_HIT_BIT = 0;
   localparam int BUS_W        = 32;

endpackage

// File: rtl/tsc_prescaler.sv
module tsc_prescaler #(
   parameter int TICK_DIV = 100
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);

   generate
      if (TICK_DIV < 1) begin : g_bad
         $error("tsc_prescaler: TICK_DIV must be at least 1");
      end else if (TICK_DIV == 1) begin : g_pass
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign tick = 1'b1;
      end else begin : g_div
         localparam int DW = $clog2(TICK_DIV);
         localparam logic [DW-1:0] LAST = DW'(TICK_DIV - 1);
         logic [DW-1:0] div_q;

         always_ff @(posedge clk) begin
            if (!rst_n)            div_q <= '0;
            else if (div_q == LAST) div_q <= '0;
            else                    div_q <= div_q + 1'b1;
         end

         assign tick = (div_q == LAST);

         AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
            tick |=> !tick);  // R1
      end
   endgenerate

endmodule

// File: rtl/tsc_counter.sv
module tsc_counter #(
   parameter int CNT_W   = 64,
   parameter int SPLIT_W = 32
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     tick,
   input  logic                     snap,
   output logic [CNT_W-1:0]         cnt,
   output logic [CNT_W-SPLIT_W-1:0] shadow
);

   localparam int HI_W = CNT_W - SPLIT_W;

   always_ff @(posedge clk) begin
      if (!rst_n)    cnt <= '0;
      else if (tick) cnt <= cnt + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    shadow <= '0;
      else if (snap) shadow <= cnt[CNT_W-1:SPLIT_W];
   end

   AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(cnt));  // R1

   AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !snap |=> $stable(shadow));  // R2

   initial begin
      if (HI_W < 1) $error("tsc_counter: upper part is empty");
   end

endmodule

// File: rtl/tsc_compare.sv
module tsc_compare
   import tsc_pkg::*;
#(
   parameter int CNT_W   = 64,
   parameter int SPLIT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [CNT_W-1:0] cnt,
   input  logic             wr_cmp_lo,
   input  logic             wr_cmp_hi,
   input  logic             wr_ctrl,
   input  logic             wr_stat,
   input  logic [BUS_W-1:0] wdata,
   output logic [CNT_W-1:0] cmp_val,
   output logic             cmp_en,
   output logic             hit,
   output logic             irq
);

   localparam int HI_W = CNT_W - SPLIT_W;

   logic [HI_W-1:0] stage_hi;
   logic [CNT_W-1:0] cnt_nxt;
   logic            match;
   logic            clr_req;
   logic            en_we;

   assign cnt_nxt = cnt + 1'b1;
   assign match   = tick && cmp_en && (cnt_nxt == cmp_val);
   assign clr_req = wr_stat && wdata[STAT_HIT_BIT];
   assign en_we   = wr_ctrl && wdata[CTRL_WE_BIT];

   always_ff @(posedge clk) begin
      if (!rst_n)         stage_hi <= '0;
      else if (wr_cmp_hi) stage_hi <= wdata[HI_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)         cmp_val <= '0;
      else if (wr_cmp_lo) cmp_val <= {stage_hi, wdata[SPLIT_W-1:0]};
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     cmp_en <= 1'b0;
      else if (en_we) cmp_en <= wdata[CTRL_EN_BIT];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       hit <= 1'b0;
      else if (match)   hit <= 1'b1;
      else if (clr_req) hit <= 1'b0;
   end

   assign irq = hit & cmp_en;

   AST_CMP_STAGED: assert property (@(posedge clk) disable iff (!rst_n)
      wr_cmp_hi |=> $stable(cmp_val));  // R3

   AST_EN_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && !wdata[CTRL_WE_BIT]) |=> $stable(cmp_en));  // R4

   AST_HIT_ON_REACH: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && cmp_en && cnt + 1'b1 == cmp_val) |=> hit);  // R5

   AST_HIT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !(wr_stat && wdata[STAT_HIT_BIT])) |=> hit);  // R6

endmodule

// File: rtl/tstamp_cmp_timer.sv
module tstamp_cmp_timer
   import tsc_pkg::*;
#(
   parameter int TICK_DIV = 100,
   parameter int CNT_W    = 64,
   parameter int SPLIT_W  = 32
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bus_wr,
   input  logic        bus_rd,
   input  logic [2:0]  bus_addr,
   input  logic [31:0] bus_wdata,
   output logic [31:0] bus_rdata,
   output logic        irq
);

   localparam int HI_W = CNT_W - SPLIT_W;

   generate
      if (SPLIT_W < 1 || SPLIT_W > BUS_W) begin : g_bad_split
         $error("tstamp_cmp_timer: SPLIT_W out of range");
      end
      if (HI_W < 1 || HI_W > BUS_W) begin : g_bad_hi
         $error("tstamp_cmp_timer: CNT_W - SPLIT_W out of range");
      end
   endgenerate

   tsc_idx_e         idx;
   logic             tick;
   logic             snap;
   logic [CNT_W-1:0] cnt;
   logic [HI_W-1:0]  shadow;
   logic [CNT_W-1:0] cmp_val;
   logic             cmp_en;
   logic             hit;

   assign idx  = tsc_idx_e'(bus_addr);
   assign snap = bus_rd && (idx == IDX_CNT_LO);

   tsc_prescaler #(.TICK_DIV(TICK_DIV)) u_presc (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick)
   );

   tsc_counter #(.CNT_W(CNT_W), .SPLIT_W(SPLIT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick),
      .snap   (snap),
      .cnt    (cnt),
      .shadow (shadow)
   );

   tsc_compare #(.CNT_W(CNT_W), .SPLIT_W(SPLIT_W)) u_cmp (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .cnt       (cnt),
      .wr_cmp_lo (bus_wr && idx == IDX_CMP_LO),
      .wr_cmp_hi (bus_wr && idx == IDX_CMP_HI),
      .wr_ctrl   (bus_wr && idx == IDX_CTRL),
      .wr_stat   (bus_wr && idx == IDX_STAT),
      .wdata     (bus_wdata),
      .cmp_val   (cmp_val),
      .cmp_en    (cmp_en),
      .hit       (hit),
      .irq       (irq)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bus_rdata <= '0;
      end else if (bus_rd) begin
         case (idx)
            IDX_CNT_LO: bus_rdata <= BUS_W'(cnt[SPLIT_W-1:0]);
            IDX_CNT_HI: bus_rdata <= BUS_W'(shadow);
            IDX_CMP_LO: bus_rdata <= BUS_W'(cmp_val[SPLIT_W-1:0]);
            IDX_CMP_HI: bus_rdata <= BUS_W'(cmp_val[CNT_W-1:SPLIT_W]);
            IDX_CTRL:   bus_rdata <= BUS_W'(cmp_en);
            IDX_STAT:   bus_rdata <= BUS_W'(hit);
            default:    bus_rdata <= '0;
         endcase
      end
   end

   AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> $stable(bus_rdata));  // R9

   AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && idx == IDX_CTRL && bus_wdata[CTRL_WE_BIT] && !bus_wdata[CTRL_EN_BIT])
      |=> !irq);  // R7

endmodule

// File: tb/tstamp_cmp_timer_bench.sv
module tstamp_cmp_timer_bench;

   localparam int  DIV   = 3;
   localparam int  CW    = 24;
   localparam int  SW    = 12;
   localparam longint LOMASK = (64'd1 << SW) - 1;
   localparam longint HIMASK = (64'd1 << (CW - SW)) - 1;
   localparam longint CMASK  = (64'd1 << CW) - 1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   tstamp_cmp_timer #(.TICK_DIV(DIV), .CNT_W(CW), .SPLIT_W(SW)) u_tstamp_cmp_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq       (irq)
   );

   // reference model: timestamp derived from edges since reset
   longint ncyc = 0;
   longint mcnt = 0, mcmp = 0, mstage = 0, mshadow = 0, mrd = 0;
   bit     men = 0, mst = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         ncyc = 0; mcnt = 0; mcmp = 0; mstage = 0; mshadow = 0; mrd = 0;
         men = 0; mst = 0;
      end else begin
         longint prev_cnt, new_cnt;
         bit     tick_now, hit_now, clr;
         prev_cnt = mcnt;
         ncyc     = ncyc + 1;
         tick_now = (ncyc % DIV) == 0;
         new_cnt  = (ncyc / DIV) & CMASK;
         hit_now  = tick_now && men && (new_cnt == mcmp);
         clr      = 1'b0;
         if (bus_rd) begin
            case (bus_addr)
               3'd0: begin mrd = prev_cnt & LOMASK; mshadow = prev_cnt >> SW; end
               3'd1: mrd = mshadow;
               3'd2: mrd = mcmp & LOMASK;
               3'd3: mrd = mcmp >> SW;
               3'd4: mrd = longint'(men);
               3'd5: mrd = longint'(mst);
               default: mrd = 0;
            endcase
         end
         if (bus_wr) begin
            case (bus_addr)
               3'd3: mstage = longint'(bus_wdata) & HIMASK;
               3'd2: mcmp = (mstage << SW) | (longint'(bus_wdata) & LOMASK);
               3'd4: if (bus_wdata[1]) men = bus_wdata[0];
               3'd5: clr = bus_wdata[0];
               default: ;
            endcase
         end
         if (hit_now)  mst = 1'b1;
         else if (clr) mst = 1'b0;
         mcnt = new_cnt;
      end
   end

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // per-clock comparison against the model
   always @(negedge clk) begin
      if (rst_n) begin
         chk(irq == (mst & men), "R7 irq vs model", longint'(irq), longint'(mst & men));
         chk(longint'(bus_rdata) == mrd, "R9 rdata vs model", longint'(bus_rdata), mrd);
      end
   end

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(input logic [2:0] a, output longint v, output longint edge_n);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      @(negedge clk);
      bus_rd = 1'b0;
      v = longint'(bus_rdata);
      edge_n = ncyc;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual expired expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      longint v, e, e2, t, hi_exp;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R9 reset state
      chk(irq == 1'b0, "R9 irq after reset", longint'(irq), 0);
      rd(3'd4, v, e); chk(v == 0, "R9 ctrl after reset", v, 0);
      rd(3'd5, v, e); chk(v == 0, "R9 status after reset", v, 0);
      rd(3'd2, v, e); chk(v == 0, "R9 compare low after reset", v, 0);
      rd(3'd1, v, e); chk(v == 0, "R9 shadow after reset", v, 0);

      // R1 rate
      repeat (10) @(negedge clk);
      rd(3'd0, v, e); chk(v == (((e - 1) / DIV) & LOMASK), "R1 count value", v, ((e - 1) / DIV) & LOMASK);
      repeat (31) @(negedge clk);
      rd(3'd0, v, e); chk(v == (((e - 1) / DIV) & LOMASK), "R1 count after wait", v, ((e - 1) / DIV) & LOMASK);

      // R8 counter writes ignored, unmapped reads zero
      wr(3'd0, 32'h0000_0abc);
      wr(3'd1, 32'h0000_0055);
      rd(3'd0, v, e); chk(v == (((e - 1) / DIV) & LOMASK), "R8 counter low write ignored", v, ((e - 1) / DIV) & LOMASK);
      rd(3'd1, v, e2); chk(v == (((e - 1) / DIV) >> SW), "R8 counter high write ignored", v, ((e - 1) / DIV) >> SW);
      rd(3'd6, v, e); chk(v == 0, "R8 unmapped index 6", v, 0);
      rd(3'd7, v, e); chk(v == 0, "R8 unmapped index 7", v, 0);

      // R4 enable guard
      wr(3'd4, 32'h1);
      rd(3'd4, v, e); chk(v == 0, "R4 enable without write-enable", v, 0);
      wr(3'd4, 32'h3);
      rd(3'd4, v, e); chk(v == 1, "R4 enable with write-enable", v, 1);
      wr(3'd4, 32'h2);
      rd(3'd4, v, e); chk(v == 0, "R4 disable with write-enable", v, 0);

      // R3 staged upper write
      wr(3'd3, 32'h5);
      rd(3'd3, v, e); chk(v == 0, "R3 upper staged only", v, 0);
      wr(3'd2, 32'h123);
      rd(3'd3, v, e); chk(v == 5, "R3 upper after low write", v, 5);
      rd(3'd2, v, e); chk(v == 32'h123, "R3 low after low write", v, 32'h123);

      // R5 disabled compare: no hit
      t = mcnt + 100;
      wr(3'd3, 32'((t >> SW) & HIMASK));
      wr(3'd2, 32'(t & LOMASK));
      while (mcnt <= t + 2) @(negedge clk);
      rd(3'd5, v, e); chk(v == 0, "R5 no hit while disabled", v, 0);

      // R5/R7 armed compare
      t = mcnt + 100;
      wr(3'd3, 32'((t >> SW) & HIMASK));
      wr(3'd2, 32'(t & LOMASK));
      wr(3'd4, 32'h3);
      while (mcnt != t - 1) @(negedge clk);
      chk(irq == 1'b0, "R5 no irq one tick early", longint'(irq), 0);
      while (mcnt != t) @(negedge clk);
      chk(irq == 1'b1, "R5 irq at compare value", longint'(irq), 1);
      rd(3'd5, v, e); chk(v == 1, "R5 status set", v, 1);

      // R4 write without write-enable keeps enable, R6 write 0 keeps flag
      wr(3'd4, 32'h0);
      chk(irq == 1'b1, "R4 irq kept by unguarded write", longint'(irq), 1);
      wr(3'd5, 32'h0);
      rd(3'd5, v, e); chk(v == 1, "R6 write zero keeps flag", v, 1);
      // R6/R7 disable keeps flag, masks irq
      wr(3'd4, 32'h2);
      chk(irq == 1'b0, "R7 irq masked when disabled", longint'(irq), 0);
      rd(3'd5, v, e); chk(v == 1, "R6 flag survives disable", v, 1);
      wr(3'd5, 32'h1);
      rd(3'd5, v, e); chk(v == 0, "R6 write one clears", v, 0);

      // R6 set wins over clear on the same edge
      t = mcnt + 100;
      wr(3'd3, 32'((t >> SW) & HIMASK));
      wr(3'd2, 32'(t & LOMASK));
      wr(3'd4, 32'h3);
      while (!(mcnt == t - 1 && ((ncyc + 1) % DIV) == 0)) @(negedge clk);
      bus_wr = 1'b1; bus_addr = 3'd5; bus_wdata = 32'h1;
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0;
      chk(irq == 1'b1, "R6 set wins over clear", longint'(irq), 1);

      // idle sequence
      wr(3'd4, 32'h2);
      wr(3'd3, 32'h0);
      wr(3'd2, 32'h0);
      wr(3'd5, 32'h1);
      rd(3'd5, v, e); chk(v == 0, "R6 idle: flag clear", v, 0);
      chk(irq == 1'b0, "R7 idle: no irq", longint'(irq), 0);

      // R2 shadow coherency across a lower wrap
      while ((mcnt & LOMASK) != LOMASK - 3) @(negedge clk);
      rd(3'd0, v, e);
      hi_exp = ((e - 1) / DIV) >> SW;
      chk(v == (((e - 1) / DIV) & LOMASK), "R2 low read near wrap", v, ((e - 1) / DIV) & LOMASK);
      repeat (30) @(negedge clk);
      rd(3'd1, v, e2);
      chk(v == hi_exp, "R2 high returns shadow", v, hi_exp);
      chk((((e2 - 1) / DIV) >> SW) != hi_exp, "R2 live upper moved on", ((e2 - 1) / DIV) >> SW, hi_exp + 1);
      rd(3'd0, v, e);
      rd(3'd1, v, e2);
      chk(v == (((e - 1) / DIV) >> SW), "R2 fresh pair consistent", v, ((e - 1) / DIV) >> SW);

      repeat (5) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule